// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of a half-duplex packet interface. It looks at each word that arrives. When a word marks the start of a packet, the block reads the destination byte from that word and decides at once whether the station wants the packet. It compares the byte against a programmable host address, and it also accepts broadcast destinations and promiscuous operation. An accepted packet's words pass through, registered, to a downstream writer. A rejected packet is dropped silently up to its end-of-packet word, and the filter then waits for the next start of packet.

The decision takes a single clock, so back-to-back minimum-length packets are each judged on their own. While the shared buffer is in use for transmission (`txBusy`), all receive traffic is ignored.

Top module: `rxaddr_filter`

## Requirements
- R1: While `rstN` is low, and on the first sample after reset, `outValid`, `outFirst`, `outLast`, `acceptFlag` and `discardFlag` are all 0.
- R2: The destination byte is `wordIn[15:8]` of a word presented with `wordValid` and `sop` both high. If that byte equals `hostAddr`, the word appears on `outWord` one cycle later with `outValid` and `outFirst` high, and `acceptFlag` pulses in that same cycle.
- R3: A destination byte of 0x00 is accepted whatever `hostAddr` holds, with the same timing as R2.
- R4: When `hostAddr` is 0x00, every destination is accepted, with the same timing as R2.
- R5: A start word that fits none of R2 to R4 is not forwarded. `discardFlag` pulses one cycle after that word, and `acceptFlag` stays low.
- R6: After a rejection, every later word of the packet up to and including the one with `eop` high produces no output. The next `sop` word is then judged afresh, including when it follows on the very next cycle.
- R7: In an accepted packet, each later valid word is forwarded one cycle after it arrives, with `outFirst` low. `outLast` is high only on the word that carried `eop`. A start word that also carries `eop` is forwarded with both `outFirst` and `outLast` high.
- R8: A valid word without `sop` that arrives outside any packet produces no output and no flag. Cycles with `wordValid` low produce no output.
- R9: A `sop` word that arrives before the current packet has ended abandons that packet and is judged as a new start word.
- R10: While `txBusy` is high, received words produce no output and no flag, and any packet in progress is abandoned. Words without `sop` that follow are then treated as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wordValid | input | 1 | A received word is present on `wordIn` |
| sop | input | 1 | The present word is the first word of a packet |
| eop | input | 1 | The present word is the last word of a packet |
| wordIn | input | 16 | Received word; destination byte in bits 15:8 |
| txBusy | input | 1 | Transmit owns the shared buffer; receive is ignored |
| hostAddr | input | 8 | Station address; 0x00 selects promiscuous mode |
| outValid | output | 1 | Forwarded word present on `outWord` |
| outWord | output | 16 | Forwarded word |
| outFirst | output | 1 | Forwarded word is the packet's first |
| outLast | output | 1 | Forwarded word is the packet's last |
| acceptFlag | output | 1 | One-cycle pulse when a packet is accepted |
| discardFlag | output | 1 | One-cycle pulse when a packet is rejected |

## Verification
Every output is due exactly one clock after the word that causes it. The forwarded word, its first and last markers, and both flag pulses come out of one register stage. The bench therefore keeps a behavioural model that advances on the same rising edge as the design. It compares all outputs at the following falling edge, after the design's registers have settled and before the next input is driven. Because inputs only change at falling edges, every comparison applies to exactly one input word, including back-to-back two-word packets and start words that arrive mid-packet.

// File: rtl/rxfilt_pkg.sv
package rxfilt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PASS = 2'd1,
    ST_DROP = 2'd2
  } rxState_e;

  typedef struct packed {
    logic fwd;
    logic first;
    logic last;
    logic accept;
    logic discard;
  } rxStrobe_t;

endpackage

// File: rtl/rxfilt_ctrl.sv
module rxfilt_ctrl
  import rxfilt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wordValid,
  input  logic      sop,
  input  logic      eop,
  input  logic      txBusy,
  input  logic      addrHit,
  output rxStrobe_t stb
);

  rxState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    if (txBusy) begin
      stateD = ST_IDLE;
    end else if (wordValid) begin
      if (sop) begin
        if (addrHit) begin
          stb.fwd    = 1'b1;
          stb.first  = 1'b1;
          stb.last   = eop;
          stb.accept = 1'b1;
          stateD     = eop ? ST_IDLE : ST_PASS;
        end else begin
          stb.discard = 1'b1;
          stateD      = eop ? ST_IDLE : ST_DROP;
        end
      end else begin
        unique case (stateQ)
          ST_PASS: begin
            stb.fwd  = 1'b1;
            stb.last = eop;
            if (eop) stateD = ST_IDLE;
          end
          ST_DROP: begin
            if (eop) stateD = ST_IDLE;
          end
          default: stateD = ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rxfilt_dp.sv
module rxfilt_dp
  import rxfilt_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 8,
  parameter bit BCAST_EN = 1'b1,
  parameter bit PROMS_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordIn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  rxStrobe_t         stb,
  output logic              addrHit,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord,
  output logic              outFirst,
  output logic              outLast,
  output logic              acceptFlag,
  output logic              discardFlag
);

  localparam int DST_LSB = WORD_W - ADDR_W;

  logic [ADDR_W-1:0] dstAddr;
  logic              exactHit, bcastHit, promsHit;

  assign dstAddr  = wordIn[WORD_W-1:DST_LSB];
  assign exactHit = (dstAddr == hostAddr);

  generate
    if (BCAST_EN) begin : g_bcast
      assign bcastHit = (dstAddr == '0);
    end else begin : g_nobcast
      assign bcastHit = 1'b0;
    end
    if (PROMS_EN) begin : g_proms
      assign promsHit = (hostAddr == '0);
    end else begin : g_noproms
      assign promsHit = 1'b0;
    end
  endgenerate

  assign addrHit = exactHit | bcastHit | promsHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outFirst    <= 1'b0;
      outLast     <= 1'b0;
      acceptFlag  <= 1'b0;
      discardFlag <= 1'b0;
    end else begin
      outValid    <= stb.fwd;
      outFirst    <= stb.fwd & stb.first;
      outLast     <= stb.fwd & stb.last;
      acceptFlag  <= stb.accept;
      discardFlag <= stb.discard;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        outWord <= '0;
    else if (stb.fwd) outWord <= wordIn;
  end

endmodule

// File: rtl/rxaddr_filter.sv
module rxaddr_filter
  import rxfilt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic              sop,
  input  logic              eop,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              txBusy,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic              outValid,
  output logic [WORD_W-1:0] outWord,
  output logic              outFirst,
  output logic              outLast,
  output logic              acceptFlag,
  output logic              discardFlag
);

  rxStrobe_t stb;
  logic      addrHit;

  rxfilt_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .sop       (sop),
    .eop       (eop),
    .txBusy    (txBusy),
    .addrHit   (addrHit),
    .stb       (stb)
  );

  rxfilt_dp #(
    .WORD_W   (WORD_W),
    .ADDR_W   (ADDR_W),
    .BCAST_EN (1'b1),
    .PROMS_EN (1'b1)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .wordIn      (wordIn),
    .hostAddr    (hostAddr),
    .stb         (stb),
    .addrHit     (addrHit),
    .outValid    (outValid),
    .outWord     (outWord),
    .outFirst    (outFirst),
    .outLast     (outLast),
    .acceptFlag  (acceptFlag),
    .discardFlag (discardFlag)
  );

endmodule

// File: rtl/rxaddr_filter_chk.sv
module rxaddr_filter_chk #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wordValid,
  input logic              sop,
  input logic              eop,
  input logic [WORD_W-1:0] wordIn,
  input logic              txBusy,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              outValid,
  input logic [WORD_W-1:0] outWord,
  input logic              outFirst,
  input logic              outLast,
  input logic              acceptFlag,
  input logic              discardFlag
);

  localparam int DST_LSB = WORD_W - ADDR_W;

  logic [ADDR_W-1:0] dst;
  logic              startIn;
  assign dst     = wordIn[WORD_W-1:DST_LSB];
  assign startIn = wordValid && sop && !txBusy;

  p_exact_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    startIn && (dst == hostAddr) |=> acceptFlag && outValid && outFirst);

  p_bcast_accept_r3: assert property (@(posedge clk) disable iff (!rstN)
    startIn && (dst == '0) |=> acceptFlag && outValid);

  p_proms_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    startIn && (hostAddr == '0) |=> acceptFlag && outValid);

  p_reject_r5: assert property (@(posedge clk) disable iff (!rstN)
    startIn && (dst != hostAddr) && (dst != '0) && (hostAddr != '0)
    |=> discardFlag && !outValid && !acceptFlag);

  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptFlag && discardFlag));

  p_single_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    startIn && eop && (dst == hostAddr) |=> outLast && outFirst);

  p_word_passthru_r7: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && !txBusy |=> !outValid || (outWord == $past(wordIn)));

  p_no_idle_out_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |=> !outValid && !acceptFlag && !discardFlag);

  p_tx_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |=> !outValid && !acceptFlag && !discardFlag);

endmodule

bind rxaddr_filter rxaddr_filter_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/rxaddr_filter_tb_top.sv
`timescale 1ns/1ps
module rxaddr_filter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0, sop = 1'b0, eop = 1'b0, txBusy = 1'b0;
  logic [15:0] wordIn = '0;
  logic [7:0]  hostAddr = 8'h5A;
  logic        outValid, outFirst, outLast, acceptFlag, discardFlag;
  logic [15:0] outWord;

  always #4 clk = ~clk;

  rxaddr_filter dut_i (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .sop(sop), .eop(eop),
    .wordIn(wordIn), .txBusy(txBusy), .hostAddr(hostAddr),
    .outValid(outValid), .outWord(outWord), .outFirst(outFirst),
    .outLast(outLast), .acceptFlag(acceptFlag), .discardFlag(discardFlag)
  );

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  // behavioural reference: 0 waiting, 1 forwarding, 2 dropping
  int          mState = 0;
  bit          eV, eF, eL, eA, eD;
  logic [15:0] eW;
  string       tag = "R1";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; eV = 0; eF = 0; eL = 0; eA = 0; eD = 0; eW = '0; tag = "R1";
    end else begin
      eV = 0; eF = 0; eL = 0; eA = 0; eD = 0;
      if (txBusy) begin
        mState = 0; tag = "R10";
      end else if (wordValid && sop) begin
        if (mState != 0) tag = "R9";
        else if (wordIn[15:8] == hostAddr) tag = "R2";
        else if (wordIn[15:8] == 8'h00) tag = "R3";
        else if (hostAddr == 8'h00) tag = "R4";
        else tag = "R5";
        if (wordIn[15:8] == hostAddr || wordIn[15:8] == 8'h00 || hostAddr == 8'h00) begin
          eV = 1; eW = wordIn; eF = 1; eL = eop; eA = 1;
          mState = eop ? 0 : 1;
        end else begin
          eD = 1;
          mState = eop ? 0 : 2;
        end
      end else if (wordValid) begin
        if (mState == 1) begin
          tag = "R7"; eV = 1; eW = wordIn; eL = eop;
          if (eop) mState = 0;
        end else if (mState == 2) begin
          tag = "R6";
          if (eop) mState = 0;
        end else tag = "R8";
      end else tag = "R8";
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (outValid !== eV || outFirst !== eF || outLast !== eL ||
          acceptFlag !== eA || discardFlag !== eD || (eV && outWord !== eW)) begin
        fails++;
        $display("FAIL %s: got v=%0b w=%h f=%0b l=%0b a=%0b d=%0b exp v=%0b w=%h f=%0b l=%0b a=%0b d=%0b",
                 tag, outValid, outWord, outFirst, outLast, acceptFlag, discardFlag,
                 eV, eW, eF, eL, eA, eD);
      end
    end
  end

  task automatic putWord(input logic [15:0] w, input bit s, input bit e);
    @(negedge clk);
    wordValid = 1; wordIn = w; sop = s; eop = e;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wordValid = 0; sop = 0; eop = 0;
    end
  endtask

  task automatic packet(input logic [7:0] dst, input int len);
    for (int i = 0; i < len; i++)
      putWord((i == 0) ? {dst, 8'h11} : 16'(16'hA000 + i), i == 0, i == len - 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: got %0d cycles exp under 50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;                       // R1 checked on reset cycles
    gap(2);
    packet(8'h5A, 3); gap(1);       // R2, R7
    packet(8'h00, 2);               // R3 back-to-back
    packet(8'h33, 4);               // R5, R6
    packet(8'h44, 2);               // R6 back-to-back reject
    packet(8'h5A, 2);               // fresh judgement after reject
    packet(8'h5A, 1); gap(1);       // R7 single-word packet
    putWord(16'h5A00, 0, 0);        // R8 stray word
    putWord(16'h5A01, 0, 1); gap(1);
    putWord(16'h5A22, 1, 0);        // R9 restart mid-packet
    putWord(16'h3322, 1, 0);
    putWord(16'h0001, 0, 1);
    putWord(16'h3300, 1, 0);
    putWord(16'h5A33, 1, 1); gap(1);
    hostAddr = 8'h00;
    packet(8'h77, 3); gap(1);       // R4
    hostAddr = 8'h5A;
    putWord(16'h5A10, 1, 0);        // R10 abandon on txBusy
    @(negedge clk); txBusy = 1; wordValid = 1; sop = 0; eop = 0;
    @(negedge clk); txBusy = 1; wordValid = 1; sop = 1; wordIn = 16'h5A00;
    @(negedge clk); txBusy = 0; wordValid = 1; sop = 0; eop = 1;
    gap(2);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      wordValid = $urandom_range(0, 3) != 0;
      sop       = $urandom_range(0, 3) == 0;
      eop       = $urandom_range(0, 2) == 0;
      txBusy    = $urandom_range(0, 15) == 0;
      case ($urandom_range(0, 3))
        0: wordIn = {8'h5A, 8'($urandom)};
        1: wordIn = {8'h00, 8'($urandom)};
        default: wordIn = 16'($urandom);
      endcase
      if ((i % 200) == 0) hostAddr = ($urandom_range(0, 1) != 0) ? 8'h5A : 8'h00;
    end
    @(negedge clk); wordValid = 0; sop = 0; eop = 0; txBusy = 0;
    gap(3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule